// File: doc/BRIEF.md
# Buffered Serial Transmitter (8/9-bit, parity, break)

This block turns characters written by a host into an asynchronous serial bit stream on one output line. A one-character holding buffer sits in front of an 11-bit shift register. While one character is being shifted out, the host can already write the next one. A finished stop bit is then followed directly by the next start bit, with no idle gap.

Each frame has a start bit (space), then 8 or 9 data bits sent least significant first, then one stop bit (mark). In 9-bit mode the ninth data bit comes from a separate control input, not from the written byte. When parity is on, the parity bit takes the position of the most significant data bit, so a frame is always 10 bits (8-bit mode) or 11 bits (9-bit mode).

Bit timing comes from a chain of counters. The chain counts either every clock cycle or only the cycles on which an alternate-source strobe is high. It runs through a programmable prescaler, a programmable baud divider and a fixed divide-by-16 stage. An empty flag and a complete flag each feed one interrupt line through their own enables. An inversion control flips the line polarity, and a break control holds the line at space.

Top module: `sertx_top`

## Requirements
- R1: After reset the line is at mark (txd = 1 with invert = 0), emptyFlag = 1 and doneFlag = 1.
- R2: In 8-bit mode without parity, a written byte is sent as a 10-bit frame: start bit 0, wrData[0] through wrData[7], then stop bit 1.
- R3: With mode9 = 1, the frame has 11 bits. The ninth data bit, sent after wrData[7], is the value of bit8 at the moment the character moves into the shift register.
- R4: With parEn = 1, the parity bit replaces the most significant data bit. That is data position 7 in 8-bit mode, where only wrData[6:0] are sent, and position 8 in 9-bit mode. The parity bit equals parOdd XOR the XOR of the data bits sent, so parOdd = 0 gives even parity.
- R5: One bit lasts (prescale+1)*(baudDiv+1)*16 source ticks. A source tick is every clock cycle when selAlt = 0, and every cycle with altTick = 1 when selAlt = 1. With selAlt = 1, the line does not change on the cycle after a cycle without altTick.
- R6: With invert = 1, every level on txd is inverted, including the idle level.
- R7: emptyFlag is 0 from the cycle after a write. It returns to 1 on the clock edge where the buffered character enters the shift register, which is also the edge where its start bit begins. A write while the buffer is still full replaces the buffered character.
- R8: doneFlag clears on a write and when a break begins. It sets when a stop bit ends with nothing pending. A character already buffered when the previous stop bit ends starts at once, with doneFlag staying 0.
- R9: irq = (emptyFlag AND emptyIe) OR (doneFlag AND doneIe).
- R10: While brk = 1, the line is held at space in whole-character units, and break takes priority over a buffered character. After brk is released, the current break character completes, then exactly one mark bit follows, and then any buffered character is sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| selAlt | input | 1 | Source select: 0 counts every clock, 1 counts altTick strobes |
| altTick | input | 1 | Alternate-source tick strobe |
| prescale | input | PRE_W | Prescaler divide minus one |
| baudDiv | input | DIV_W | Baud divider divide minus one |
| mode9 | input | 1 | 1 selects 9 data bits |
| bit8 | input | 1 | Ninth data bit in 9-bit mode |
| parEn | input | 1 | Parity enable |
| parOdd | input | 1 | 1 selects odd parity |
| invert | input | 1 | Output polarity inversion |
| brk | input | 1 | Break control |
| emptyIe | input | 1 | Interrupt enable for emptyFlag |
| doneIe | input | 1 | Interrupt enable for doneFlag |
| wrEn | input | 1 | Host write strobe to the data buffer |
| wrData | input | 8 | Character written by the host |
| txd | output | 1 | Serial output line |
| emptyFlag | output | 1 | Buffer empty flag |
| doneFlag | output | 1 | Transmission complete flag |
| irq | output | 1 | Interrupt request |

## Verification
On every cycle, the assertions check the flag responses to a host write. They also check that a rising empty flag coincides with a start-bit level on the line, that the line rests at mark whenever the complete flag is set, and that the line holds still when the alternate source gives no tick. Frame contents need the bench's scenarios: bit order, the ninth bit, parity placement and sense, and the exact bit period under different divider settings. So do back-to-back frames after a buffer overwrite, and the break sequence with its single trailing mark bit ahead of a pending character.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
  localparam int FRAME_W = 11;

  typedef struct packed {
    logic loadData;
    logic loadBreak;
    logic loadStop;
    logic shift;
  } txStrobe_t;
endpackage

// File: rtl/sertx_ctrl.sv
module sertx_ctrl import sertx_pkg::*; #(
  parameter int PRE_W = 3,
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             selAlt,
  input  logic             altTick,
  input  logic [PRE_W-1:0] prescale,
  input  logic [DIV_W-1:0] baudDiv,
  input  logic             mode9,
  input  logic             brk,
  input  logic             bufFull,
  input  logic             wrEn,
  output txStrobe_t        stb,
  output logic             doneFlag
);
  localparam int OVS   = 16;
  localparam int OVS_W = $clog2(OVS);
  localparam logic [OVS_W-1:0] OVS_LAST = OVS_W'(OVS - 1);
  localparam int CNT_W = $clog2(FRAME_W + 1);

  logic [PRE_W-1:0] preCnt;
  logic [DIV_W-1:0] divCnt;
  logic [OVS_W-1:0] ovsCnt;
  logic srcEn, preWrap, divWrap, bitTick;

  assign srcEn   = selAlt ? altTick : 1'b1;
  assign preWrap = srcEn && (preCnt == prescale);
  assign divWrap = preWrap && (divCnt == baudDiv);
  assign bitTick = divWrap && (ovsCnt == OVS_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
      divCnt <= '0;
      ovsCnt <= '0;
    end else begin
      if (srcEn)   preCnt <= preWrap ? '0 : preCnt + 1'b1;
      if (preWrap) divCnt <= divWrap ? '0 : divCnt + 1'b1;
      if (divWrap) ovsCnt <= ovsCnt + 1'b1;
    end
  end

  logic [CNT_W-1:0] bitsLeft, nextLeft, charLen;
  logic inBreak, nextBreak, setDone, clrDone;

  assign charLen = mode9 ? CNT_W'(FRAME_W) : CNT_W'(FRAME_W - 1);

  always_comb begin
    stb       = '0;
    nextLeft  = bitsLeft;
    nextBreak = inBreak;
    setDone   = 1'b0;
    if (bitTick) begin
      if (bitsLeft > CNT_W'(1)) begin
        stb.shift = 1'b1;
        nextLeft  = bitsLeft - 1'b1;
      end else if (brk) begin
        stb.loadBreak = 1'b1;
        nextLeft      = charLen;
        nextBreak     = 1'b1;
      end else if (inBreak) begin
        stb.loadStop = 1'b1;
        nextLeft     = CNT_W'(1);
        nextBreak    = 1'b0;
      end else if (bufFull) begin
        stb.loadData = 1'b1;
        nextLeft     = charLen;
      end else begin
        nextLeft = '0;
        setDone  = (bitsLeft == CNT_W'(1));
      end
    end
    clrDone = wrEn || stb.loadBreak;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitsLeft <= '0;
      inBreak  <= 1'b0;
      doneFlag <= 1'b1;
    end else begin
      bitsLeft <= nextLeft;
      inBreak  <= nextBreak;
      if (clrDone)      doneFlag <= 1'b0;
      else if (setDone) doneFlag <= 1'b1;
    end
  end
endmodule

// File: rtl/sertx_dp.sv
module sertx_dp import sertx_pkg::*; (
  input  logic       clk,
  input  logic       rstN,
  input  txStrobe_t  stb,
  input  logic       wrEn,
  input  logic [7:0] wrData,
  input  logic       mode9,
  input  logic       bit8,
  input  logic       parEn,
  input  logic       parOdd,
  input  logic       invert,
  output logic       bufFull,
  output logic       txd
);
  logic [7:0]         bufData;
  logic [8:0]         dat9;
  logic [FRAME_W-1:0] frame, sr;

  always_comb begin
    dat9 = {bit8, bufData};
    if (mode9) begin
      if (parEn) dat9[8] = parOdd ^ (^bufData);
      frame = {1'b1, dat9, 1'b0};
    end else begin
      if (parEn) dat9[7] = parOdd ^ (^bufData[6:0]);
      frame = {2'b11, dat9[7:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bufData <= '0;
      bufFull <= 1'b0;
      sr      <= '1;
    end else begin
      if (wrEn) bufData <= wrData;
      if (wrEn)              bufFull <= 1'b1;
      else if (stb.loadData) bufFull <= 1'b0;
      if (stb.loadData)       sr <= frame;
      else if (stb.loadBreak) sr <= '0;
      else if (stb.loadStop)  sr <= '1;
      else if (stb.shift)     sr <= {1'b1, sr[FRAME_W-1:1]};
    end
  end

  assign txd = sr[0] ^ invert;
endmodule

// File: rtl/sertx_top.sv
module sertx_top import sertx_pkg::*; #(
  parameter int PRE_W = 3,
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             selAlt,
  input  logic             altTick,
  input  logic [PRE_W-1:0] prescale,
  input  logic [DIV_W-1:0] baudDiv,
  input  logic             mode9,
  input  logic             bit8,
  input  logic             parEn,
  input  logic             parOdd,
  input  logic             invert,
  input  logic             brk,
  input  logic             emptyIe,
  input  logic             doneIe,
  input  logic             wrEn,
  input  logic [7:0]       wrData,
  output logic             txd,
  output logic             emptyFlag,
  output logic             doneFlag,
  output logic             irq
);
  txStrobe_t stb;
  logic      bufFull;

  sertx_ctrl #(.PRE_W(PRE_W), .DIV_W(DIV_W)) uCtrl (
    .clk(clk), .rstN(rstN), .selAlt(selAlt), .altTick(altTick),
    .prescale(prescale), .baudDiv(baudDiv), .mode9(mode9), .brk(brk),
    .bufFull(bufFull), .wrEn(wrEn), .stb(stb), .doneFlag(doneFlag)
  );

  sertx_dp uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrEn(wrEn), .wrData(wrData),
    .mode9(mode9), .bit8(bit8), .parEn(parEn), .parOdd(parOdd),
    .invert(invert), .bufFull(bufFull), .txd(txd)
  );

  assign emptyFlag = !bufFull;
  assign irq = (emptyFlag && emptyIe) || (doneFlag && doneIe);
endmodule

// File: rtl/sertx_chk.sv
module sertx_chk (
  input logic clk,
  input logic rstN,
  input logic wrEn,
  input logic selAlt,
  input logic altTick,
  input logic invert,
  input logic txd,
  input logic emptyFlag,
  input logic doneFlag
);
  a_r7_write_clears_empty: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> !emptyFlag);

  a_r8_write_clears_done: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> !doneFlag);

  a_r7_empty_rise_at_start: assert property (@(posedge clk) disable iff (!rstN)
    $rose(emptyFlag) |-> (txd == invert));

  a_r8_done_line_at_mark: assert property (@(posedge clk) disable iff (!rstN)
    doneFlag |-> (txd == !invert));

  a_r5_hold_without_source: assert property (@(posedge clk) disable iff (!rstN)
    (selAlt && !altTick) |=> ($stable(txd) || !$stable(invert)));
endmodule

bind sertx_top sertx_chk uChk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .selAlt(selAlt), .altTick(altTick),
  .invert(invert), .txd(txd), .emptyFlag(emptyFlag), .doneFlag(doneFlag)
);

// File: tb/tb_sertx_top.sv
module tb_sertx_top;
  logic clk = 1'b0, rstN = 1'b0;
  logic selAlt = 0, altTick, mode9 = 0, bit8 = 0, parEn = 0, parOdd = 0;
  logic invert = 0, brk = 0, emptyIe = 1, doneIe = 0, wrEn = 0;
  logic [2:0] prescale = 0;
  logic [7:0] baudDiv = 0, wrData = 0;
  logic txd, emptyFlag, doneFlag, irq;
  int checks = 0, errors = 0, altCnt = 0;

  always #4 clk = ~clk;
  always @(negedge clk) altCnt <= (altCnt == 2) ? 0 : altCnt + 1;
  assign altTick = (altCnt == 2);

  sertx_top dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [10:0] expFrame(input logic [7:0] d, input logic m9,
      input logic b8, input logic pe, input logic po);
    logic [8:0] v;
    v = {b8, d};
    if (m9) begin
      if (pe) v[8] = po ^ (^d);
      return {1'b1, v, 1'b0};
    end
    if (pe) v[7] = po ^ (^d[6:0]);
    return {2'b11, v[7:0], 1'b0};
  endfunction

  function automatic int period();
    return (int'(prescale) + 1) * (int'(baudDiv) + 1) * 16 * (selAlt ? 3 : 1);
  endfunction

  task automatic checkIrq(input string tag);
    chk({tag, " R9 irq"}, irq, (emptyFlag & emptyIe) | (doneFlag & doneIe));
  endtask

  task automatic writeChar(input logic [7:0] d);
    @(negedge clk); wrEn = 1; wrData = d;
    @(negedge clk); wrEn = 0;
    chk("R7 empty clears after write", emptyFlag, 0);
    chk("R8 done clears after write", doneFlag, 0);
  endtask

  task automatic waitStart();
    int n = 0;
    while (txd !== invert && n < 20000) begin @(negedge clk); n++; end
    if (n >= 20000) chk("R2 start bit seen", 0, 1);
  endtask

  task automatic waitDone();
    int n = 0;
    while (doneFlag !== 1'b1 && n < 20000) begin @(negedge clk); n++; end
    if (n >= 20000) chk("R8 done reached", 0, 1);
  endtask

  task automatic checkFrame(input string req, input logic [10:0] f,
      input int len, input int firstWait);
    int bad = 0;
    repeat (firstWait) @(negedge clk);
    for (int k = 0; k < len; k++) begin
      if (k > 0) repeat (period()) @(negedge clk);
      if (txd !== (f[k] ^ invert)) begin
        bad++;
        $display("FAIL %s: bit %0d actual %0b expected %0b", req, k, txd, f[k] ^ invert);
      end
    end
    checks++;
    if (bad != 0) errors++;
  endtask

  task automatic oneFrame(input logic [7:0] d);
    logic [10:0] f = expFrame(d, mode9, bit8, parEn, parOdd);
    int len = mode9 ? 11 : 10;
    writeChar(d);
    waitStart();
    chk("R7 empty set at start bit", emptyFlag, 1);
    checkFrame(mode9 ? (parEn ? "R3 R4 frame" : "R3 frame") : (parEn ? "R4 frame" : "R2 frame"),
               f, len, period() / 2);
    repeat (period() / 2 + 2) @(negedge clk);
    chk("R8 done after stop", doneFlag, 1);
    chk("R6 idle level", txd, !invert);
    checkIrq("post-frame");
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk("R1 idle line", txd, 1);
    chk("R1 empty", emptyFlag, 1);
    chk("R1 done", doneFlag, 1);
    checkIrq("R1 reset");

    // R6: inverted idle
    invert = 1; @(negedge clk);
    chk("R6 inverted idle", txd, 0);
    invert = 0; @(negedge clk);

    // R5: exact bit period, clock source and alternate source
    for (int s = 0; s < 2; s++) begin
      selAlt = s[0]; prescale = 1; baudDiv = 2;
      repeat (4) @(negedge clk);
      writeChar(8'h01);
      waitStart();
      repeat (period() - 1) @(negedge clk);
      chk("R5 start still active at period-1", txd, 0);
      @(negedge clk);
      chk("R5 data bit after one period", txd, 1);
      waitDone();
    end

    // Directed: 9-bit with bit8, parity odd/even
    selAlt = 0; prescale = 0; baudDiv = 0;
    mode9 = 1; bit8 = 1; oneFrame(8'hA5);
    mode9 = 1; parEn = 1; parOdd = 0; oneFrame(8'h07);
    mode9 = 0; parEn = 1; parOdd = 1; oneFrame(8'hFF);
    parEn = 0;

    // Random frames
    for (int i = 0; i < 16; i++) begin
      mode9 = 1'($urandom); bit8 = 1'($urandom); parEn = 1'($urandom);
      parOdd = 1'($urandom); invert = 1'($urandom); selAlt = 1'($urandom);
      prescale = 3'($urandom_range(0, 1)); baudDiv = 8'($urandom_range(0, 2));
      emptyIe = 1'($urandom); doneIe = 1'($urandom);
      repeat (4) @(negedge clk);
      checkIrq("random idle");
      oneFrame(8'($urandom));
    end

    // R7 overwrite + R8 back-to-back
    mode9 = 0; parEn = 0; invert = 0; selAlt = 0; prescale = 0; baudDiv = 0;
    repeat (4) @(negedge clk);
    begin
      int n = 0;
      @(negedge clk); wrEn = 1; wrData = 8'h3C;
      @(negedge clk); wrEn = 0;
      while (emptyFlag !== 1'b1 && n < 100) begin @(negedge clk); n++; end
      wrEn = 1; wrData = 8'h11; @(negedge clk);
      wrData = 8'hC6; @(negedge clk);
      wrEn = 0;
      checkFrame("R8 first of pair", expFrame(8'h3C, 0, 0, 0, 0), 10, period() / 2 - 2);
      chk("R8 done low while pending", doneFlag, 0);
      checkFrame("R7 overwrite sends last write", expFrame(8'hC6, 0, 0, 0, 0), 10, period());
      repeat (period() / 2 + 2) @(negedge clk);
      chk("R8 done after pair", doneFlag, 1);
    end

    // R10 break
    begin
      int bad = 0, n = 0, cnt = 0;
      brk = 1;
      repeat (period() + 2) @(negedge clk);
      chk("R10 line at space in break", txd, 0);
      chk("R10 done cleared by break", doneFlag, 0);
      writeChar(8'h5A);
      for (int j = 0; j < 60; j++) begin
        repeat (8) @(negedge clk);
        if (txd !== 1'b0) bad++;
      end
      chk("R10 break held over pending char", bad, 0);
      brk = 0;
      while (txd !== 1'b1 && n < 12 * period()) begin @(negedge clk); n++; end
      chk("R10 mark after release", txd, 1);
      while (txd === 1'b1 && cnt < 1000) begin cnt++; @(negedge clk); end
      chk("R10 single mark bit length", cnt, period());
      checkFrame("R10 pending char after break", expFrame(8'h5A, 0, 0, 0, 0), 10, period() / 2);
      waitDone();
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule